// File: doc/BRIEF.md
# Serial Command and Display-RAM Controller

This block receives a four-wire serial stream for a multiplexed segment LCD controller and keeps the display memory and display mode that a separate scanner reads. A host lowers the chip-select line and shifts bytes in most significant bit first on the rising edge of a shift clock. The level of a side-band command/data line at the eighth edge of each byte decides what the byte is. A command byte is decoded. A data byte is written into a 32-word by 4-bit display RAM.

The block keeps a 5-bit address counter. A data byte writes two neighbouring words and moves the counter forward by two. The nibble-rewrite command writes one word and moves the counter forward by one. Each completed frame is passed from the shift-clock domain to the system-clock domain through a toggle-synchronised holding register. The display scanner reads the RAM through an asynchronous read port and reads the mode from a 2-bit output.

Top module: `lcd_serial_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `disp_mode_o` reads 0 (off), every RAM word reads 0 and the address counter is 0.
- R2: Serial bits are taken on rising `sck_i` edges while `cs_ni` is low, most significant bit first, in 8-bit frames. A high-to-low transition of `cs_ni` restarts the bit count, so a partial frame is discarded.
- R3: A frame is a command if `cmd_i` is high at its eighth rising edge and display data if `cmd_i` is low there. The level of `cmd_i` at the other seven edges has no effect.
- R4: The command `000aaaaa` loads `aaaaa` into the address counter.
- R5: The commands `001xxxxx`, `010xxxxx` and `011xxxxx` set `disp_mode_o` to 1 (all on), 0 (off) and 2 (normal) respectively. None of them changes any RAM word or the address counter.
- R6: A data byte `hhhhllll` writes `hhhh` to word A and `llll` to word (A+1) mod 32, where A is the current address. The address then becomes (A+2) mod 32. RAM bit 3 receives the most significant bit of each nibble.
- R7: The command `100xdddd` writes `dddd` to word A and sets the address to (A+1) mod 32. Bit 4 is ignored.
- R8: Address increments wrap from 31 to 0, including the second word of a data byte written at address 31.
- R9: The command `110xxxxx` sets the mode to 0 (off) and the address to 0, and leaves the RAM contents unchanged.
- R10: Commands with top bits `101` or `111` change neither the RAM, the mode nor the address.
- R11: Rising `sck_i` edges while `cs_ni` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data, MSB first |
| cmd_i | input | 1 | Command (1) / data (0) select, sampled at the 8th edge |
| rd_addr_i | input | 5 | Scanner read address |
| rd_data_o | output | 4 | RAM word at `rd_addr_i` |
| disp_mode_o | output | 2 | 0 = off, 1 = all on, 2 = normal |

## Verification
The bench builds the block with its default parameters: 5 address bits, 4-bit words and two synchroniser stages. Because the RAM has only 32 words, every check reads back the whole RAM. Each address is written once through an address-set command followed by a rewrite. The counter is then made to wrap by both the +1 step and the +2 step, so any write that reaches a wrong word is detected anywhere in the memory. The framing cases are also exercised: a truncated frame, clock edges while deselected, and a command/data line that changes just before the eighth edge.

// File: rtl/lcd_ctrl_pkg.sv
package lcd_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ALL  = 2'd1,
    MODE_NORM = 2'd2
  } disp_mode_e;

  typedef enum logic [2:0] {
    OP_ADDR  = 3'b000,
    OP_ALLON = 3'b001,
    OP_OFF   = 3'b010,
    OP_NORM  = 3'b011,
    OP_REWR  = 3'b100,
    OP_RST   = 3'b110
  } opcode_e;
endpackage

// File: rtl/lcd_ser_rx.sv
module lcd_ser_rx #(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               cmd_i,
  output logic               vld_o,
  output logic               is_cmd_o,
  output logic [FRAME_W-1:0] bits_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W:0]   hold_q;
  logic               tog_q;

  // bit counter restarts whenever select is released
  always_ff @(posedge sck_i or posedge cs_ni or negedge rst_ni) begin
    if (!rst_ni || cs_ni) cnt_q <= '0;
    else                  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else if (!cs_ni) begin
      sh_q <= {sh_q[FRAME_W-3:0], sdi_i};
      if (cnt_q == LAST) begin
        hold_q <= {cmd_i, sh_q, sdi_i};
        tog_q  <= ~tog_q;
      end
    end
  end

  logic [SYNC_STAGES:0] sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
  end

  assign vld_o    = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign is_cmd_o = hold_q[FRAME_W];
  assign bits_o   = hold_q[FRAME_W-1:0];
endmodule

// File: rtl/lcd_cmd_dec.sv
module lcd_cmd_dec
  import lcd_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic                is_cmd_i,
  input  logic [2*NIB_W-1:0]  bits_i,
  output logic                wa_en_o,
  output logic [ADDR_W-1:0]   wa_addr_o,
  output logic [NIB_W-1:0]    wa_data_o,
  output logic                wb_en_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  output logic [NIB_W-1:0]    wb_data_o,
  output logic [ADDR_W-1:0]   addr_o,
  output disp_mode_e          mode_o
);
  localparam int FW = 2 * NIB_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  disp_mode_e        mode_q, mode_d;
  logic [2:0]        op;

  assign op = bits_i[FW-1:FW-3];

  always_comb begin
    wa_en_o   = 1'b0;
    wb_en_o   = 1'b0;
    wa_addr_o = addr_q;
    wb_addr_o = addr_q + ADDR_W'(1);
    wa_data_o = bits_i[NIB_W-1:0];
    wb_data_o = bits_i[NIB_W-1:0];
    addr_d    = addr_q;
    mode_d    = mode_q;
    if (vld_i) begin
      if (!is_cmd_i) begin
        wa_en_o   = 1'b1;
        wb_en_o   = 1'b1;
        wa_data_o = bits_i[FW-1:NIB_W];
        addr_d    = addr_q + ADDR_W'(2);
      end else begin
        case (op)
          OP_ADDR:  addr_d = bits_i[ADDR_W-1:0];
          OP_ALLON: mode_d = MODE_ALL;
          OP_OFF:   mode_d = MODE_OFF;
          OP_NORM:  mode_d = MODE_NORM;
          OP_REWR: begin
            wa_en_o = 1'b1;
            addr_d  = addr_q + ADDR_W'(1);
          end
          OP_RST: begin
            mode_d = MODE_OFF;
            addr_d = '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mode_q <= MODE_OFF;
    end else begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr_o = addr_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/lcd_dram.sv
module lcd_dram #(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_en_i,
  input  logic [ADDR_W-1:0] wa_addr_i,
  input  logic [NIB_W-1:0]  wa_data_i,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [NIB_W-1:0]  wb_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][NIB_W-1:0] mem_q;

  // the two ports never address the same word (DEPTH >= 2)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wa_en_i && wa_addr_i == ADDR_W'(i)) mem_q[i] <= wa_data_i;
        else if (wb_en_i && wb_addr_i == ADDR_W'(i)) mem_q[i] <= wb_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/lcd_serial_ctrl.sv
module lcd_serial_ctrl
  import lcd_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o,
  output logic [1:0]        disp_mode_o
);
  localparam int FRAME_W = 2 * NIB_W;

  logic               frame_vld, frame_cmd;
  logic [FRAME_W-1:0] frame_bits;
  logic               wa_en, wb_en;
  logic [ADDR_W-1:0]  wa_addr, wb_addr, addr_q;
  logic [NIB_W-1:0]   wa_data, wb_data;
  disp_mode_e         mode_q;

  lcd_ser_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i, .cmd_i,
    .vld_o(frame_vld), .is_cmd_o(frame_cmd), .bits_o(frame_bits)
  );

  lcd_cmd_dec #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) i_dec (
    .clk_i, .rst_ni,
    .vld_i(frame_vld), .is_cmd_i(frame_cmd), .bits_i(frame_bits),
    .wa_en_o(wa_en), .wa_addr_o(wa_addr), .wa_data_o(wa_data),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .addr_o(addr_q), .mode_o(mode_q)
  );

  lcd_dram #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) i_ram (
    .clk_i, .rst_ni,
    .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .rd_addr_i, .rd_data_o
  );

  assign disp_mode_o = mode_q;
endmodule

// File: rtl/lcd_serial_ctrl_chk.sv
module lcd_serial_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld,
  input logic              frame_cmd,
  input logic [7:0]        frame_bits,
  input logic [ADDR_W-1:0] addr_q,
  input logic [1:0]        disp_mode_o
);
  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && frame_cmd && frame_bits[7:5] == 3'b000
    |=> addr_q == $past(frame_bits[ADDR_W-1:0])); // R4
  AST_MODE_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && frame_cmd && frame_bits[7:5] inside {3'b001, 3'b010, 3'b011}
    |=> $stable(addr_q)); // R5
  AST_DATA_STEP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && !frame_cmd |=> addr_q == $past(addr_q) + ADDR_W'(2)); // R6
  AST_REWR_STEP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && frame_cmd && frame_bits[7:5] == 3'b100
    |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R7
  AST_RST_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && frame_cmd && frame_bits[7:5] == 3'b110
    |=> addr_q == '0 && disp_mode_o == 2'd0); // R9
  AST_UNUSED_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld && frame_cmd && frame_bits[7:5] inside {3'b101, 3'b111}
    |=> $stable(addr_q) && $stable(disp_mode_o)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |=> $stable(addr_q) && $stable(disp_mode_o)); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld |=> !frame_vld); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_mode_o != 2'd3); // R5
endmodule

bind lcd_serial_ctrl lcd_serial_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_vld(frame_vld), .frame_cmd(frame_cmd),
  .frame_bits(frame_bits), .addr_q(addr_q), .disp_mode_o(disp_mode_o)
);

// File: tb/test_lcd_serial_ctrl.sv
`timescale 1ns/1ps
module test_lcd_serial_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0, cmd = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic [1:0] mode;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [3:0] exp_ram [32];
  int exp_mode = 0;
  logic [4:0] exp_addr = '0;

  always #10 clk = ~clk;

  lcd_serial_ctrl i_lcd_serial_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .cmd_i(cmd), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .disp_mode_o(mode)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(req, int'(rd_data), int'(exp_ram[a]));
    end
    chk(req, int'(mode), exp_mode);
  endtask

  // pre: level of cmd on edges 1..7, last: level on edge 8
  task automatic send(logic [7:0] b, logic last, logic pre);
    cs_ni = 1'b0;
    #40;
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      cmd = (i == 0) ? last : pre;
      #80 sck = 1'b1;
      #80 sck = 1'b0;
    end
    #40 cs_ni = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  // reference model, computed from the requirements
  task automatic model(logic [7:0] b, logic is_cmd);
    if (!is_cmd) begin
      exp_ram[exp_addr] = b[7:4];
      exp_ram[5'(exp_addr + 5'd1)] = b[3:0];
      exp_addr = exp_addr + 5'd2;
    end else begin
      case (b[7:5])
        3'b000: exp_addr = b[4:0];
        3'b001: exp_mode = 1;
        3'b010: exp_mode = 0;
        3'b011: exp_mode = 2;
        3'b100: begin exp_ram[exp_addr] = b[3:0]; exp_addr = exp_addr + 5'd1; end
        3'b110: begin exp_mode = 0; exp_addr = '0; end
        default: ;
      endcase
    end
  endtask

  task automatic xfer(logic [7:0] b, logic is_cmd);
    send(b, is_cmd, is_cmd);
    model(b, is_cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 32; a++) exp_ram[a] = '0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");

    // R4 R7: every address via address-set plus rewrite, bit 4 set as junk
    for (int a = 0; a < 32; a++) begin
      xfer(8'(a), 1'b1);
      xfer({3'b100, 1'b1, 4'((a * 7 + 3) & 15)}, 1'b1);
    end
    check_all("R4 R7 sweep");

    // R6: data bytes from address 30 across the wrap
    xfer(8'd30, 1'b1);
    for (int k = 0; k < 17; k++) xfer(8'((k * 37 + 11) & 255), 1'b0);
    check_all("R6 R8 data bytes");

    // R8: data byte at 31 then rewrite shows address is 1
    xfer(8'h1F, 1'b1);
    xfer(8'hA5, 1'b0);
    xfer(8'h8C, 1'b1);
    check_all("R8 data wrap");
    xfer(8'h1F, 1'b1);
    xfer(8'h83, 1'b1);
    xfer(8'h89, 1'b1);
    check_all("R8 rewrite wrap");

    // R5: modes, with junk low bits
    xfer(8'h3B, 1'b1); check_all("R5 all on");
    xfer(8'h7F, 1'b1); check_all("R5 normal");
    xfer(8'h55, 1'b1); check_all("R5 off");
    xfer(8'h60, 1'b1);
    xfer(8'h86, 1'b1); check_all("R5 address kept");

    // R3: cmd differs on edges 1..7 from edge 8
    send(8'h27, 1'b0, 1'b1); model(8'h27, 1'b0);
    check_all("R3 data despite early cmd high");
    send(8'h20, 1'b1, 1'b0); model(8'h20, 1'b1);
    check_all("R3 command despite early cmd low");

    // R2: partial frame discarded by cs release
    cs_ni = 1'b0;
    #40;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; cmd = 1'b1;
      #80 sck = 1'b1;
      #80 sck = 1'b0;
    end
    #40 cs_ni = 1'b1;
    #200;
    xfer(8'h4E, 1'b0);
    check_all("R2 truncated frame");

    // R11: edges with cs high
    sdi = 1'b1; cmd = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #80 sck = 1'b1;
      #80 sck = 1'b0;
    end
    xfer(8'h91, 1'b1);
    check_all("R11 deselected edges");

    // R10: unused opcodes
    xfer(8'h60, 1'b1);
    xfer(8'hA7, 1'b1);
    xfer(8'hFF, 1'b1);
    check_all("R10 unused opcodes");
    xfer(8'h8D, 1'b1);
    check_all("R10 address kept");

    // R9: reset command, RAM kept, address 0
    xfer(8'h0B, 1'b1);
    xfer(8'h20, 1'b1);
    xfer(8'hDF, 1'b1);
    check_all("R9 reset command");
    xfer(8'h8E, 1'b1);
    check_all("R9 address zero");

    // R1: pin reset mid-run
    xfer(8'h60, 1'b1);
    @(negedge clk) rst_ni = 1'b0;
    for (int a = 0; a < 32; a++) exp_ram[a] = '0;
    exp_mode = 0; exp_addr = '0;
    check_all("R1 pin reset");
    @(negedge clk) rst_ni = 1'b1;
    xfer(8'h85, 1'b1);
    check_all("R1 address cleared");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule